// File: doc/BRIEF.md
# Glitch-free clock source switcher

This block picks the system clock from three free-running, mutually asynchronous sources: a primary oscillator, a slow secondary oscillator and an internal oscillator. A 2-bit selection is presented on `sel_i` at any time but only acted upon when a one-cycle switch trigger arrives on the control clock. On a trigger that names a different source, the block parks the outgoing clock low, hands the request across to the incoming clock domain, lets that clock run unseen for a fixed number of rising edges, and only then opens its gate to the output.

Each source has its own gate whose enable flop is clocked on that source's falling edge, so a gate opens or closes only while its clock is low and the output never carries a clipped pulse. The request travels into each source domain through a synchronizer, and each gate's state travels back to the control domain the same way, so the old gate is provably closed before the new one starts counting. Three status outputs tell the rest of the chip which source is running and settled.

Top module: `clk_src_switch`

## Requirements
- R1: A change of `sel_i` without a trigger leaves the output source and the status outputs unchanged.
- R2: A trigger naming a source other than the active one stops the output low, then restarts it from the newly selected source.
- R3: Between the last falling edge of the old output and the first rising edge from the new source, the new source produces 8 or 9 rising edges that do not reach `clk_o`; that first rising edge is itself a new-source edge.
- R4: No high or low phase of `clk_o` is shorter than the shorter half period of the two sources involved; at most one source gate is open at any time.
- R5: Once settled, `clk_o` has the period of the selected source.
- R6: Encoding of `sel_i`: 2'b00 primary, 2'b01 secondary, 2'b10 and 2'b11 internal.
- R7: `pri_run_o` is high only while primary is active and settled, `sec_run_o` only while secondary is, and all three status outputs are low from the trigger until the new source is released; `sec_run_o` is never high together with another status output.
- R8: With `pri_int_i` high (primary fed by the internal oscillator) and `int_ok_i` high, primary operation raises both `pri_run_o` and `int_stable_o`; switching to the internal source then drops `pri_run_o` and keeps `int_stable_o`.
- R9: `int_stable_o` is high only while `int_ok_i` is high; with the internal source active and `int_ok_i` low, all status outputs are low.
- R10: A trigger naming the already active source causes no pause and leaves the status outputs set.
- R11: A trigger arriving while a switch is still in progress is ignored; the switch completes to its original target.
- R12: After reset the primary source is chosen, `clk_o` stays low and all status outputs are low until primary has been released, and the first output rising edge is the 9th primary rising edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock for selection and handshake |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_pri_i | input | 1 | Primary oscillator |
| clk_sec_i | input | 1 | Slow secondary oscillator |
| clk_int_i | input | 1 | Internal oscillator |
| sel_i | input | 2 | Requested source, encoded per R6 |
| trig_i | input | 1 | One-cycle switch trigger on `clk_i` |
| pri_int_i | input | 1 | Primary source is the internal oscillator |
| int_ok_i | input | 1 | Internal oscillator is stable at full rate |
| clk_o | output | 1 | Switched system clock |
| pri_run_o | output | 1 | Primary active and settled |
| sec_run_o | output | 1 | Secondary active and settled |
| int_stable_o | output | 1 | Internal oscillator active (or feeding primary) and stable |

## Verification
The bench keeps the defaults, a settle count of 8 with 2-stage synchronizers, which makes six swallowed edges after the synchronizer and a gap small enough to count edge by edge. Source half periods of 7.1, 31.3 and 11.7 ns against a 4 ns control clock keep every source period longer than the return handshake, so the swallowed-edge count must land on exactly 8 or 9. With only three sources, all six ordered transitions plus both internal encodings, the same-source trigger and the mid-switch trigger are walked through in one run.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;
  localparam int unsigned NSRC = 3;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_OFF = 2'd1,
    ST_ON  = 2'd2
  } sw_state_e;

  function automatic src_e sel_decode(input logic [1:0] sel);
    case (sel)
      2'b00:   return SRC_PRI;
      2'b01:   return SRC_SEC;
      default: return SRC_INT;
    endcase
  endfunction
endpackage

// File: rtl/clk_sw_sync.sv
module clk_sw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/clk_sw_gate.sv
module clk_sw_gate #(
  parameter int unsigned SETTLE      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_src_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic en_o,
  output logic clk_o
);
  // synchronizer edges count toward the settle window
  localparam int unsigned CNT_TGT = SETTLE - SYNC_STAGES;
  localparam int unsigned CW      = $clog2(CNT_TGT + 1);

  logic          req_s;
  logic [CW-1:0] cnt_q;
  logic          en_q;

  clk_sw_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (clk_src_i),
    .rst_ni (rst_ni),
    .d_i    (req_i),
    .q_o    (req_s)
  );

  always_ff @(posedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!req_s)               cnt_q <= '0;
    else if (cnt_q != CW'(CNT_TGT)) cnt_q <= cnt_q + 1'b1;
  end

  // enable moves only while the source is low
  always_ff @(negedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= req_s && (cnt_q == CW'(CNT_TGT));
  end

  assign en_o  = en_q;
  assign clk_o = clk_src_i & en_q;
endmodule

// File: rtl/clk_sw_ctl.sv
module clk_sw_ctl
  import clk_sw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      sel_i,
  input  logic            trig_i,
  input  logic [NSRC-1:0] en_i,
  output logic [NSRC-1:0] req_o,
  output logic            run_o,
  output src_e            cur_o,
  output src_e            tgt_o
);
  logic [NSRC-1:0] ack_s;
  logic [NSRC-1:0] req_q;
  sw_state_e       st_q;
  src_e            cur_q, tgt_q, nxt_src;

  for (genvar k = 0; k < NSRC; k++) begin : g_ack
    clk_sw_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (en_i[k]),
      .q_o    (ack_s[k])
    );
  end

  always_comb nxt_src = sel_decode(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ON;
      cur_q <= SRC_PRI;
      tgt_q <= SRC_PRI;
      req_q <= NSRC'(1);
    end else begin
      case (st_q)
        ST_RUN: if (trig_i && nxt_src != cur_q) begin
          tgt_q        <= nxt_src;
          req_q[cur_q] <= 1'b0;
          st_q         <= ST_OFF;
        end
        ST_OFF: if (!ack_s[cur_q]) begin
          req_q[tgt_q] <= 1'b1;
          st_q         <= ST_ON;
        end
        ST_ON: if (ack_s[tgt_q]) begin
          cur_q <= tgt_q;
          st_q  <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign req_o = req_q;
  assign run_o = (st_q == ST_RUN);
  assign cur_o = cur_q;
  assign tgt_o = tgt_q;
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clk_sw_pkg::*;
#(
  parameter int unsigned SETTLE      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clk_pri_i,
  input  logic       clk_sec_i,
  input  logic       clk_int_i,
  input  logic [1:0] sel_i,
  input  logic       trig_i,
  input  logic       pri_int_i,
  input  logic       int_ok_i,
  output logic       clk_o,
  output logic       pri_run_o,
  output logic       sec_run_o,
  output logic       int_stable_o
);
  logic [NSRC-1:0] src_clk, gate_req, gate_en, gate_clk;
  logic            ctl_run;
  src_e            ctl_cur, ctl_tgt;

  assign src_clk = {clk_int_i, clk_sec_i, clk_pri_i};

  clk_sw_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .trig_i (trig_i),
    .en_i   (gate_en),
    .req_o  (gate_req),
    .run_o  (ctl_run),
    .cur_o  (ctl_cur),
    .tgt_o  (ctl_tgt)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_gate
    clk_sw_gate #(.SETTLE(SETTLE), .SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_src_i (src_clk[k]),
      .rst_ni    (rst_ni),
      .req_i     (gate_req[k]),
      .en_o      (gate_en[k]),
      .clk_o     (gate_clk[k])
    );
  end

  assign clk_o        = |gate_clk;
  assign pri_run_o    = ctl_run && (ctl_cur == SRC_PRI);
  assign sec_run_o    = ctl_run && (ctl_cur == SRC_SEC);
  assign int_stable_o = ctl_run && int_ok_i &&
                        ((ctl_cur == SRC_INT) || (ctl_cur == SRC_PRI && pri_int_i));
endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk
  import clk_sw_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] sel_i,
  input logic       trig_i,
  input logic       pri_int_i,
  input logic       int_ok_i,
  input logic       pri_run_o,
  input logic       sec_run_o,
  input logic       int_stable_o,
  input logic [2:0] en_i,
  input logic       run_i,
  input src_e       cur_i,
  input src_e       tgt_i
);
  p_one_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_i));

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !trig_i) |=> $stable(cur_i));

  p_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(tgt_i));

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_run_o && (pri_run_o || int_stable_o)));

  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !(pri_run_o || sec_run_o || int_stable_o));

  p_int_ok_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_stable_o |-> int_ok_i);

  p_dual_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_run_o && int_stable_o) |-> pri_int_i);

  p_same_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && trig_i && sel_decode(sel_i) == cur_i) |=> run_i);
endmodule

bind clk_src_switch clk_src_switch_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_i        (sel_i),
  .trig_i       (trig_i),
  .pri_int_i    (pri_int_i),
  .int_ok_i     (int_ok_i),
  .pri_run_o    (pri_run_o),
  .sec_run_o    (sec_run_o),
  .int_stable_o (int_stable_o),
  .en_i         (gate_en),
  .run_i        (ctl_run),
  .cur_i        (ctl_cur),
  .tgt_i        (ctl_tgt)
);

// File: tb/clk_src_switch_test.sv
`timescale 1ns/1ps
module clk_src_switch_test;
  localparam realtime HALF_CTL = 2.0;
  localparam realtime HALF_PRI = 7.1;
  localparam realtime HALF_SEC = 31.3;
  localparam realtime HALF_INT = 11.7;

  logic clk_i = 1'b0, clk_pri = 1'b0, clk_sec = 1'b0, clk_int = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] sel_i = 2'b00;
  logic trig_i = 1'b0, pri_int_i = 1'b0, int_ok_i = 1'b1;
  logic clk_o, pri_run_o, sec_run_o, int_stable_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  clk_src_switch uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_pri_i(clk_pri), .clk_sec_i(clk_sec),
    .clk_int_i(clk_int), .sel_i(sel_i), .trig_i(trig_i), .pri_int_i(pri_int_i),
    .int_ok_i(int_ok_i), .clk_o(clk_o), .pri_run_o(pri_run_o),
    .sec_run_o(sec_run_o), .int_stable_o(int_stable_o)
  );

  always #(HALF_CTL) clk_i = ~clk_i;
  initial begin #1.3; forever #(HALF_PRI) clk_pri = ~clk_pri; end
  initial begin #3.7; forever #(HALF_SEC) clk_sec = ~clk_sec; end
  initial begin #0.9; forever #(HALF_INT) clk_int = ~clk_int; end

  // edge counters and output monitor
  int cnt_pri = 0, cnt_sec = 0, cnt_int = 0;
  int snap_pri = 0, snap_sec = 0, snap_int = 0;
  int gap_d [3];
  int gap_seen = 0;
  realtime last_fall = 0.0, last_edge = -1.0, min_pulse = 1.0e9, t_rise = 0.0;

  always @(posedge clk_pri) cnt_pri++;
  always @(posedge clk_sec) cnt_sec++;
  always @(posedge clk_int) cnt_int++;

  always @(clk_o) begin
    if (last_edge >= 0.0 && ($realtime - last_edge) < min_pulse)
      min_pulse = $realtime - last_edge;
    last_edge = $realtime;
  end

  always @(negedge clk_o) begin
    last_fall = $realtime;
    #0.1;
    snap_pri = cnt_pri; snap_sec = cnt_sec; snap_int = cnt_int;
  end

  always @(posedge clk_o) begin
    t_rise = $realtime;
    #0.1;
    if (t_rise - last_fall > 40.0) begin
      gap_seen++;
      gap_d[0] = cnt_pri - snap_pri - 1;
      gap_d[1] = cnt_sec - snap_sec - 1;
      gap_d[2] = cnt_int - snap_int - 1;
    end
  end

  function automatic realtime half_of(int k);
    return (k == 0) ? HALF_PRI : (k == 1) ? HALF_SEC : HALF_INT;
  endfunction

  // expected status vector {pri_run, sec_run, int_stable}
  function automatic logic [2:0] exp_flags(int k);
    logic p, s, i;
    p = (k == 0);
    s = (k == 1);
    i = int_ok_i && (k == 2 || (k == 0 && pri_int_i));
    return {p, s, i};
  endfunction

  function automatic logic [2:0] flags();
    return {pri_run_o, sec_run_o, int_stable_o};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_trig(logic [1:0] s);
    @(negedge clk_i);
    sel_i  = s;
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
  endtask

  task automatic wait_settle(int k);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if ((k == 0 && pri_run_o) || (k == 1 && sec_run_o) || (k == 2 && int_stable_o)) break;
    end
  endtask

  task automatic check_period(int k, string req);
    realtime t1, diff;
    @(posedge clk_o); t1 = $realtime;
    @(posedge clk_o); diff = $realtime - t1;
    check((diff - 2.0*half_of(k)) < 0.05 && (2.0*half_of(k) - diff) < 0.05, req,
          "output period x100ps", int'(diff*100.0), int'(2.0*half_of(k)*100.0));
  endtask

  task automatic do_switch(logic [1:0] s, int k);
    gap_seen = 0;
    pulse_trig(s);
    check(flags() == 3'b000, "R7", "status during switch", int'(flags()), 0);
    wait_settle(k);
    #300;
    check(gap_seen == 1, "R2", "stop then restart count", gap_seen, 1);
    check(gap_d[k] == 8 || gap_d[k] == 9, "R3", "swallowed new edges", gap_d[k], 8);
    check(flags() == exp_flags(k), "R6", "status after settle", int'(flags()), int'(exp_flags(k)));
    check_period(k, "R5");
  endtask

  initial begin
    int snap_rst, d;
    #50;
    check(clk_o == 1'b0 && flags() == 3'b000, "R12", "in reset outputs", int'({clk_o, flags()}), 0);
    #53;
    rst_ni = 1'b1;
    #0.1;
    snap_rst = cnt_pri;
    check(flags() == 3'b000, "R12", "status after release", int'(flags()), 0);
    @(posedge clk_o);
    #0.1;
    d = cnt_pri - snap_rst;
    check(d == 9, "R12", "first output edge index", d, 9);
    wait_settle(0);
    #100;
    check(flags() == 3'b100, "R12", "primary status", int'(flags()), 4);
    check_period(0, "R12");

    // R1: select moves without trigger
    gap_seen = 0;
    @(negedge clk_i); sel_i = 2'b01;
    #500;
    check(flags() == 3'b100 && gap_seen == 0, "R1", "untriggered select", int'(flags()), 4);
    check_period(0, "R1");

    // R10: trigger to the active source
    gap_seen = 0;
    pulse_trig(2'b00);
    check(flags() == 3'b100, "R10", "status after same trigger", int'(flags()), 4);
    #400;
    check(gap_seen == 0, "R10", "pause count", gap_seen, 0);

    // all ordered transitions, both internal encodings
    do_switch(2'b01, 1);
    do_switch(2'b10, 2);
    do_switch(2'b00, 0);
    do_switch(2'b11, 2);
    do_switch(2'b01, 1);
    do_switch(2'b00, 0);

    // R8: primary fed by internal oscillator
    @(negedge clk_i); pri_int_i = 1'b1;
    @(negedge clk_i);
    check(flags() == 3'b101, "R8", "dual status on primary", int'(flags()), 5);
    do_switch(2'b10, 2);
    check(flags() == 3'b001, "R8", "primary flag dropped on internal", int'(flags()), 1);
    @(negedge clk_i); pri_int_i = 1'b0;

    // R9: internal not yet stable
    @(negedge clk_i); int_ok_i = 1'b0;
    @(negedge clk_i);
    check(flags() == 3'b000, "R9", "status with internal unstable", int'(flags()), 0);
    @(negedge clk_i); int_ok_i = 1'b1;
    @(negedge clk_i);
    check(flags() == 3'b001, "R9", "status with internal stable", int'(flags()), 1);

    // R11: second trigger mid switch
    gap_seen = 0;
    pulse_trig(2'b01);
    repeat (10) @(negedge clk_i);
    pulse_trig(2'b00);
    wait_settle(1);
    #300;
    check(flags() == 3'b010, "R11", "switch target kept", int'(flags()), 2);
    check(gap_seen == 1, "R11", "single pause", gap_seen, 1);
    check_period(1, "R11");

    check(min_pulse > HALF_PRI - 0.01, "R4", "shortest output phase x100ps",
          int'(min_pulse*100.0), int'(HALF_PRI*100.0));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule